// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block sends and receives character-framed asynchronous serial data. Each direction has its own first-in first-out buffer, so a host can queue several characters for sending and collect several received characters at its own pace. The host pushes bytes into the transmit buffer and pops received bytes from the head of the receive buffer. Fill levels for both buffers are visible at all times.

The character format is set by static configuration inputs: 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. Every bit lasts 16 periods of an oversampling tick. The tick comes from one of two sources. The first is an internal divider that produces one tick every N+1 system clocks and also drives a 16x clock out on a pin. The second is an external 16x clock input, which is synchronised and edge-detected.

The receiver confirms a start bit on the eighth tick after the falling edge, then samples each later bit at its centre. It stores parity-error and framing-error flags with each character. It reports line breaks and lost characters as one-cycle pulses.

Top module: `uart_fifo_xcvr`

## Requirements
- R1: Each buffer holds up to 16 characters and reports its level. A push into a full buffer is ignored, and a pop from an empty buffer is ignored.
- R2: The transmitter waits for a tick, pops the buffer head, and sends a low start bit. It then sends the data bits least significant first, the optional parity bit, and one or two high stop bits. Every bit lasts exactly 16 ticks, and the line idles high.
- R3: With 7-bit length, only data bits 6..0 are sent, and a received character reads back with bit 7 equal to 0.
- R4: The parity bit makes the count of ones across the data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R5: In internal mode a tick occurs every `cfg_div`+1 system clocks. `sck_out` is high for the first floor((`cfg_div`+1)/2) clocks of each tick period and low for the rest.
- R6: In external mode each rising edge of `ext_clk_in` gives one tick, `cfg_div` has no effect, and `sck_out` stays low.
- R7: A low pulse on `rxd` that has ended before the eighth tick after the falling edge produces no character.
- R8: A received character whose parity bit is wrong has `rx_perr`=1 stored with it. A correct parity bit gives `rx_perr`=0.
- R9: A character whose first stop bit samples low has `rx_ferr`=1 stored with it. The receiver then waits for `rxd` to go high before it looks for a new start bit.
- R10: If the data bits, the parity bit and the stop bit all sample low, the receiver pulses `rx_break` for one cycle and stores nothing. Reception resumes after the line returns high.
- R11: If a character completes while the receive buffer is full, `rx_overrun` pulses for one cycle, the character is discarded, and the buffered characters are kept in order.
- R12: `rx_ready` is 1 exactly when the receive level is non-zero, and `rx_full` is 1 exactly when it is 16.
- R13: After reset `txd` is high, both levels are 0, and `rx_ready`, `rx_full` and `tx_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits on transmit |
| cfg_ext_clk | input | 1 | 1 takes the tick from ext_clk_in |
| cfg_div | input | DIV_W | Internal divider value N |
| ext_clk_in | input | 1 | External 16x bit-rate clock |
| sck_out | output | 1 | Internal 16x clock, driven out |
| tx_push | input | 1 | Writes tx_data into the transmit buffer |
| tx_data | input | 8 | Character to send |
| tx_full | output | 1 | Transmit buffer full |
| tx_level | output | LVL_W | Characters waiting to be sent |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_pop | input | 1 | Removes the receive buffer head |
| rx_data | output | 8 | Receive buffer head character |
| rx_perr | output | 1 | Parity error flag of the head |
| rx_ferr | output | 1 | Framing error flag of the head |
| rx_ready | output | 1 | Receive buffer not empty |
| rx_full | output | 1 | Receive buffer full |
| rx_level | output | LVL_W | Characters held in the receive buffer |
| rx_overrun | output | 1 | One-cycle pulse when a character is lost |
| rx_break | output | 1 | One-cycle pulse when a break is detected |

## Verification
The assertions assume that the format inputs and `cfg_div` change only while no character is in flight. They also assume that `ext_clk_in`, in external mode, toggles more slowly than every two system clocks, so each synchronised rising edge is seen as one separate tick. The stimulus changes the format only after a transmitter drain or a received character. It runs the external clock with an 8-clock period, and it holds every driven `rxd` bit for exactly 16 ticks.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } line_st_e;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    localparam logic [3:0] LAST_TICK = 4'd15;
    localparam logic [3:0] MID_TICK  = 4'd7;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != LW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign level = q.cnt;

    // R1: a push into a full buffer leaves it full
    p_full_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == LW'(DEPTH) && push && !pop) |=> (q.cnt == LW'(DEPTH)));
    // R1: a pop from an empty buffer leaves it empty
    p_empty_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && pop && !push) |=> (q.cnt == '0));
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick,
    output logic             sck
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       sync;
        logic             sck;
    } baud_st_t;

    baud_st_t q, d;
    logic [DIV_W:0] half;

    always_comb begin
        d      = q;
        d.sync = {q.sync[1:0], ext_clk};
        half   = ({1'b0, div} + 1'b1) >> 1;
        if (ext_sel) begin
            tick  = q.sync[1] & ~q.sync[2];
            d.cnt = '0;
            d.sck = 1'b0;
        end else begin
            tick  = (q.cnt >= div);
            d.cnt = tick ? '0 : q.cnt + 1'b1;
            d.sck = ({1'b0, d.cnt} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck = q.sck;

    // R5: with a divider above zero, internal ticks never come back to back
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ext_sel && div != '0 && $stable(div)) |=> (!tick || ext_sel || div != $past(div)));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic       empty,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd
);
    typedef struct packed {
        line_st_e   st;
        logic [3:0] tcnt;
        logic [2:0] bidx;
        logic [7:0] sh;
        logic       par;
        logic       second;
        logic       line;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{st: S_IDLE, tcnt: '0, bidx: '0, sh: '0,
                                  par: 1'b0, second: 1'b0, line: 1'b1};

    tx_st_t q, d;
    logic load;
    logic [7:0] mask;
    logic [2:0] last;

    always_comb begin
        d    = q;
        load = 1'b0;
        mask = fmt.len7 ? 8'h7F : 8'hFF;
        last = fmt.len7 ? 3'd6 : 3'd7;
        case (q.st)
            S_IDLE: begin
                d.line = 1'b1;
                if (tick && !empty) load = 1'b1;
            end
            default: begin
                if (tick) begin
                    d.tcnt = q.tcnt + 4'd1;
                    if (q.tcnt == LAST_TICK) begin
                        case (q.st)
                            S_START: begin
                                d.st   = S_DATA;
                                d.bidx = '0;
                                d.line = q.sh[0];
                            end
                            S_DATA: begin
                                if (q.bidx == last) begin
                                    if (fmt.par_en) begin
                                        d.st   = S_PAR;
                                        d.line = q.par;
                                    end else begin
                                        d.st     = S_STOP;
                                        d.second = 1'b0;
                                        d.line   = 1'b1;
                                    end
                                end else begin
                                    d.bidx = q.bidx + 3'd1;
                                    d.sh   = q.sh >> 1;
                                    d.line = q.sh[1];
                                end
                            end
                            S_PAR: begin
                                d.st     = S_STOP;
                                d.second = 1'b0;
                                d.line   = 1'b1;
                            end
                            default: begin
                                if (fmt.stop2 && !q.second) d.second = 1'b1;
                                else if (!empty)            load     = 1'b1;
                                else                        d.st     = S_IDLE;
                            end
                        endcase
                    end
                end
            end
        endcase
        if (load) begin
            d.st   = S_START;
            d.tcnt = '0;
            d.sh   = din;
            d.par  = (^(din & mask)) ^ fmt.par_odd;
            d.line = 1'b0;
        end
        pop = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

    assign txd = q.line;

    // R2: bit timing advances only on a tick
    p_tcnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && q.st != S_IDLE) |=> $stable(q.tcnt));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       len7,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    input  logic       full_i,
    output logic       push,
    output logic [9:0] wdata,
    output logic       ovr,
    output logic       brk
);
    typedef struct packed {
        line_st_e   st;
        logic [3:0] tcnt;
        logic [2:0] bidx;
        logic [7:0] sh;
        logic       acc;
        logic       zero;
        logic [1:0] sync;
        logic       push;
        logic [9:0] wd;
        logic       ovr;
        logic       brk;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{st: S_IDLE, tcnt: '0, bidx: '0, sh: '0, acc: 1'b0,
                                  zero: 1'b0, sync: 2'b11, push: 1'b0, wd: '0,
                                  ovr: 1'b0, brk: 1'b0};

    rx_st_t q, d;
    logic rx, perr, ferr;
    logic [7:0] byte_v;
    logic [2:0] last;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        d.push = 1'b0;
        d.ovr  = 1'b0;
        d.brk  = 1'b0;
        rx     = q.sync[1];
        last   = len7 ? 3'd6 : 3'd7;
        perr   = par_en & q.acc;
        ferr   = ~rx;
        byte_v = len7 ? {1'b0, q.sh[7:1]} : q.sh;
        case (q.st)
            S_IDLE: begin
                if (tick && !rx) begin
                    d.st   = S_START;
                    d.tcnt = 4'd1;
                end
            end
            S_START: begin
                if (tick) begin
                    if (q.tcnt == MID_TICK) begin
                        if (!rx) begin
                            d.st   = S_DATA;
                            d.tcnt = '0;
                            d.bidx = '0;
                            d.sh   = '0;
                            d.acc  = par_odd;
                            d.zero = 1'b1;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 4'd1;
                    end
                end
            end
            S_HOLD: begin
                if (rx) d.st = S_IDLE;
            end
            default: begin
                if (tick) begin
                    d.tcnt = q.tcnt + 4'd1;
                    if (q.tcnt == LAST_TICK) begin
                        case (q.st)
                            S_DATA: begin
                                d.sh   = {rx, q.sh[7:1]};
                                d.acc  = q.acc ^ rx;
                                d.zero = q.zero & ~rx;
                                if (q.bidx == last) d.st = par_en ? S_PAR : S_STOP;
                                else                d.bidx = q.bidx + 3'd1;
                            end
                            S_PAR: begin
                                d.acc  = q.acc ^ rx;
                                d.zero = q.zero & ~rx;
                                d.st   = S_STOP;
                            end
                            default: begin
                                d.st = rx ? S_IDLE : S_HOLD;
                                if (ferr && q.zero) begin
                                    d.brk = 1'b1;
                                end else if (full_i) begin
                                    d.ovr = 1'b1;
                                end else begin
                                    d.push = 1'b1;
                                    d.wd   = {ferr, perr, byte_v};
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign push  = q.push;
    assign wdata = q.wd;
    assign ovr   = q.ovr;
    assign brk   = q.brk;

    // R11: a lost character is only reported when the buffer was full
    p_ovr_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> $past(full_i));
    // R10: a break never writes a character
    p_brk_nopush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk |-> !q.push);
endmodule

// File: rtl/uart_fifo_xcvr.sv
module uart_fifo_xcvr
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 12,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_len7,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_stop2,
    input  logic             cfg_ext_clk,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             ext_clk_in,
    output logic             sck_out,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    output logic             tx_full,
    output logic [LVL_W-1:0] tx_level,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_ready,
    output logic             rx_full,
    output logic [LVL_W-1:0] rx_level,
    output logic             rx_overrun,
    output logic             rx_break
);
    logic       tick;
    logic       tx_pop;
    logic [7:0] tx_head;
    logic       rx_push;
    logic [9:0] rx_wdata, rx_head;
    fmt_t       fmt;

    assign fmt = '{len7: cfg_len7, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .ext_sel(cfg_ext_clk), .div(cfg_div),
        .ext_clk(ext_clk_in), .tick(tick), .sck(sck_out)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .level(tx_level)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
        .empty(tx_level == '0), .din(tx_head), .pop(tx_pop), .txd(txd)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len7(cfg_len7),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd), .rxd(rxd), .full_i(rx_full),
        .push(rx_push), .wdata(rx_wdata), .ovr(rx_overrun), .brk(rx_break)
    );

    uart_fifo #(.W(10), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_head), .level(rx_level)
    );

    assign tx_full  = (tx_level == LVL_W'(DEPTH));
    assign rx_full  = (rx_level == LVL_W'(DEPTH));
    assign rx_ready = (rx_level != '0);
    assign rx_ferr  = rx_head[9];
    assign rx_perr  = rx_head[8];
    assign rx_data  = rx_head[7:0];
endmodule

// File: tb/uart_fifo_xcvr_tb.sv
module uart_fifo_xcvr_tb;
    localparam int CLK_P   = 10;
    localparam int DIV     = 3;
    localparam int BIT_CLK = 16 * (DIV + 1);

    // {len7, par_en, par_odd, stop2, data}
    localparam logic [11:0] VEC [8] = '{
        {4'b0000, 8'hA5}, {4'b1000, 8'hD3}, {4'b0100, 8'h3C}, {4'b0110, 8'h7E},
        {4'b1101, 8'h2B}, {4'b0001, 8'h00}, {4'b1110, 8'h81}, {4'b0111, 8'hFF}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_ext_clk = 0;
    logic [11:0] cfg_div = 12'(DIV);
    logic ext_clk_in = 1'b0, ext_run = 1'b0;
    logic sck_out, tx_push = 1'b0, tx_full, txd, rxd, rx_pop = 1'b0;
    logic [7:0] tx_data = 8'h00, rx_data;
    logic [4:0] tx_level, rx_level;
    logic rx_perr, rx_ferr, rx_ready, rx_full, rx_overrun, rx_break;
    logic loop_en = 1'b0, rxd_drv = 1'b1;
    int n_chk = 0, n_err = 0, brk_cnt = 0, ovr_cnt = 0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #(CLK_P / 2) clk = ~clk;
    always #(4 * CLK_P) if (ext_run) ext_clk_in = ~ext_clk_in;

    always @(posedge clk) begin
        if (rx_break)   brk_cnt++;
        if (rx_overrun) ovr_cnt++;
    end

    uart_fifo_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_ext_clk(cfg_ext_clk),
        .cfg_div(cfg_div), .ext_clk_in(ext_clk_in), .sck_out(sck_out),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_level(tx_level),
        .txd(txd), .rxd(rxd), .rx_pop(rx_pop), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_ready(rx_ready), .rx_full(rx_full), .rx_level(rx_level),
        .rx_overrun(rx_overrun), .rx_break(rx_break)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_fmt(input logic [3:0] f);
        @(negedge clk);
        {cfg_len7, cfg_par_en, cfg_par_odd, cfg_stop2} = f;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_byte();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 4000 && !rx_ready; i++) @(negedge clk);
    endtask

    task automatic hold_bit(input logic v);
        rxd_drv = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit low_stop);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) hold_bit(b[i]);
        if (cfg_par_en)
            hold_bit((^(b & (cfg_len7 ? 8'h7F : 8'hFF))) ^ cfg_par_odd ^ bad_par);
        hold_bit(!low_stop);
        if (cfg_stop2) hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic start_len(output int c);
        int k = 0;
        while (txd && k < 5000) begin k++; @(negedge clk); end
        c = 0;
        while (!txd && c < 5000) begin c++; @(negedge clk); end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

    initial begin
        int c, hc, lc, b0, o0, mism;
        logic [11:0] fr;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(txd == 1'b1, "R13 txd idle", txd, 1);
        chk(tx_level == 0 && rx_level == 0, "R13 levels", {tx_level, rx_level}, 0);
        chk(!rx_ready && !rx_full && !tx_full, "R13 flags", {rx_ready, rx_full, tx_full}, 0);

        // R5: sck_out duty with divider 3
        for (int i = 0; i < 20 && sck_out; i++) @(negedge clk);
        for (int i = 0; i < 20 && !sck_out; i++) @(negedge clk);
        hc = 0; while (sck_out && hc < 100) begin hc++; @(negedge clk); end
        lc = 0; while (!sck_out && lc < 100) begin lc++; @(negedge clk); end
        chk(hc == 2 && lc == 2, "R5 sck_out shape", hc * 16 + lc, 2 * 16 + 2);

        // R5: bit length with internal divider
        set_fmt(4'b0000);
        push_byte(8'h01);
        start_len(c);
        chk(c == BIT_CLK, "R5 internal bit length", c, BIT_CLK);
        repeat (12 * BIT_CLK) @(negedge clk);

        // R6: external clock, 8 clocks per tick
        cfg_ext_clk = 1'b1;
        ext_run = 1'b1;
        hc = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); hc += sck_out; end
        chk(hc == 0, "R6 sck_out low in external mode", hc, 0);
        push_byte(8'h01);
        start_len(c);
        chk(c == 128, "R6 external bit length", c, 128);
        repeat (12 * 128) @(negedge clk);
        cfg_ext_clk = 1'b0;
        ext_run = 1'b0;
        repeat (20) @(negedge clk);

        // R2 / R4: waveform, 8 bits, odd parity, two stops
        set_fmt(4'b0111);
        push_byte(8'hA5);
        for (int i = 0; i < 5000 && txd; i++) @(negedge clk);
        repeat (BIT_CLK / 2) @(negedge clk);
        fr = {1'b1, 1'b1, 1'b1, 8'hA5, 1'b0};
        for (int i = 0; i < 12; i++) begin
            chk(txd == fr[i], (i == 9) ? "R4 parity bit" : "R2 frame bit", i * 2 + txd, i * 2 + fr[i]);
            repeat (BIT_CLK) @(negedge clk);
        end
        repeat (BIT_CLK) @(negedge clk);

        // R1: transmit buffer caps at 16
        set_fmt(4'b0000);
        @(negedge clk);
        for (int k = 0; k < 18; k++) begin
            tx_data = 8'(k);
            tx_push = 1'b1;
            @(negedge clk);
        end
        tx_push = 1'b0;
        @(negedge clk);
        chk(tx_level == 16 && tx_full, "R1 tx buffer full", tx_level, 16);
        for (int i = 0; i < 20000 && tx_level != 0; i++) @(negedge clk);
        repeat (12 * BIT_CLK) @(negedge clk);

        // R2 / R3 / R4: loopback table
        loop_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            set_fmt(VEC[v][11:8]);
            push_byte(VEC[v][7:0]);
            wait_ready();
            chk(rx_ready && rx_data == (VEC[v][11] ? VEC[v][7:0] & 8'h7F : VEC[v][7:0]),
                "R3 loopback data", rx_data, VEC[v][11] ? VEC[v][7:0] & 8'h7F : VEC[v][7:0]);
            chk(!rx_perr && !rx_ferr, "R4 loopback flags", {rx_ferr, rx_perr}, 0);
            pop_byte();
        end
        repeat (2 * BIT_CLK) @(negedge clk);
        loop_en = 1'b0;

        // R8: parity errors, even then odd
        set_fmt(4'b0100);
        send_frame(8'h3C, 0, 0);
        wait_ready();
        chk(rx_data == 8'h3C && !rx_perr, "R8 good parity", {rx_perr, rx_data}, 8'h3C);
        pop_byte();
        send_frame(8'h3C, 1, 0);
        wait_ready();
        chk(rx_data == 8'h3C && rx_perr, "R8 bad parity", {rx_perr, rx_data}, 9'h13C);
        pop_byte();
        set_fmt(4'b0110);
        send_frame(8'h3C, 0, 0);
        wait_ready();
        chk(rx_ready && !rx_perr, "R8 odd parity ok", rx_perr, 0);
        pop_byte();

        // R9: framing error
        set_fmt(4'b0100);
        send_frame(8'h81, 0, 1);
        wait_ready();
        chk(rx_data == 8'h81 && rx_ferr, "R9 framing error", {rx_ferr, rx_data}, 9'h181);
        pop_byte();

        // R10: break
        b0 = brk_cnt;
        @(negedge clk);
        hold_bit(1'b0);
        repeat (11) hold_bit(1'b0);
        repeat (2) hold_bit(1'b1);
        chk(brk_cnt == b0 + 1, "R10 break pulse", brk_cnt - b0, 1);
        chk(rx_level == 0, "R10 break not stored", rx_level, 0);
        send_frame(8'h5A, 0, 0);
        wait_ready();
        chk(rx_data == 8'h5A, "R10 resume after break", rx_data, 8'h5A);
        pop_byte();

        // R7: short low pulse
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (5 * (DIV + 1)) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        chk(rx_level == 0, "R7 glitch rejected", rx_level, 0);

        // R11 / R12: fill, then overrun
        for (int i = 0; i < 16; i++) send_frame(8'(i + 16), 0, 0);
        chk(rx_level == 16 && rx_full && rx_ready, "R12 full flags", rx_level, 16);
        o0 = ovr_cnt;
        send_frame(8'hEE, 0, 0);
        chk(ovr_cnt == o0 + 1, "R11 overrun pulse", ovr_cnt - o0, 1);
        chk(rx_level == 16 && rx_data == 8'h10, "R11 contents kept", rx_data, 8'h10);
        mism = 0;
        for (int i = 0; i < 16; i++) begin
            if (rx_data != 8'(i + 16)) mism++;
            pop_byte();
        end
        chk(mism == 0, "R11 order preserved", mism, 0);
        chk(!rx_ready && rx_level == 0, "R12 empty after drain", rx_level, 0);
        pop_byte();
        chk(rx_level == 0, "R1 pop on empty ignored", rx_level, 0);

        summary();
    end
endmodule